// File: doc/BRIEF.md
# Multiplexed ADC Readout Sequencer

This block runs the serial readout of an analog multiplexer front-end chip. A start pulse launches a sequence in which each multiplex clock tick moves the chip to its next channel, after which the block pulses the ADC convert strobe and waits for the ADC busy line to drop before it captures the sample. The chip raises a shift-out flag once its chain has been fully clocked. The level of that flag at capture time is kept with each sample. After the last channel, one further tick clears the flag. That tick starts no conversion.

The samples are held in a small local store. Once the trailing tick has been issued, they are written to the output FIFO in front-panel connector order rather than in the order the chip presents them. Each FIFO word carries the sample, the connector output number and the end-of-chain flag. A separate host read port returns a fixed firmware version at one register address. Host reads have no effect on the sequence or on the FIFO.

Top module: `mux_adc_readout`

## Requirements
- R1: A start pulse while idle produces NUM_CH multiplex ticks, each followed by exactly one ADC convert strobe, and then one further tick with no convert strobe: NUM_CH+1 ticks and NUM_CH conversions per completed readout.
- R2: The FIFO write strobe never coincides with a tick or a convert strobe. Exactly NUM_CH words are written per completed readout, all of them after the final (NUM_CH+1-th) tick.
- R3: FIFO word layout: bits [15:0] hold the captured sample, bits [20:16] hold the connector output number, and bit 21 holds the shift-out flag level sampled when that conversion's busy line fell. Bits [31:22] are zero.
- R4: Word j of a readout carries connector output j. Chip channel k (0-based) maps to output 2k for k < (NUM_CH+1)/2, and otherwise to output 2(k-(NUM_CH+1)/2)+1.
- R5: With a chip whose flag rises only after the last channel's tick, bit 21 is set in the final word of the readout and clear in every other word.
- R6: A sample is captured only when ADC busy is low, and no earlier than the second cycle after the convert strobe. Data presented while busy is high is never stored.
- R7: If busy stays high for TIMEOUT_CYC cycles after a convert strobe, timeout_err is set, the sequencer returns to idle and no words are written. The next start clears timeout_err.
- R8: A start pulse while a readout is in progress is ignored.
- R9: Synchronous reset returns the block to idle, with tick, convert strobe, FIFO write, busy and timeout_err all low from the next cycle.
- R10: A host read with address VERSION_ADDR (49) returns VERSION on host_rd_data one cycle later. Any other address returns zero. Host reads never start a readout or write the FIFO.
- R11: The tick and the convert strobe are each one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, returns to idle |
| start | input | 1 | Start-of-readout pulse |
| mux_clk | output | 1 | Multiplex clock tick to the front-end chip |
| adc_conv | output | 1 | ADC convert strobe |
| adc_busy | input | 1 | ADC conversion in progress |
| adc_data | input | 16 | ADC sample |
| shift_flag | input | 1 | Chip end-of-chain shift-out flag |
| fifo_wr | output | 1 | FIFO write enable |
| fifo_wdata | output | 32 | FIFO write word |
| busy | output | 1 | Readout in progress |
| timeout_err | output | 1 | ADC busy timeout occurred in last readout |
| host_rd_en | input | 1 | Host register read request |
| host_rd_addr | input | 8 | Host register read address |
| host_rd_data | output | 32 | Host register read data |

## Verification
The bench keeps the default of 18 channels, so the real connector reorder and its odd/even split are exercised in full, together with the end-of-chain flag on channel 17. TIMEOUT_CYC is set to 24, so a stuck busy line expires quickly, while random ADC latencies of 1 to 6 cycles stay well inside that window. VERSION is set to a distinctive value so that a version read cannot be mistaken for the zero returned by neighbouring addresses.

// File: rtl/mux_rd_pkg.sv
package mux_rd_pkg;

    localparam int SAMPLE_W = 16;
    localparam int IDX_W    = 5;
    localparam int WORD_W   = 32;
    localparam int PAD_W    = WORD_W - SAMPLE_W - IDX_W - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TICK,
        ST_CONV,
        ST_WAIT,
        ST_FLUSH,
        ST_DRAIN
    } seq_state_e;

    // Flag lands on bit SAMPLE_W + IDX_W = 21
    typedef struct packed {
        logic [PAD_W-1:0]    pad;
        logic                last;
        logic [IDX_W-1:0]    panel;
        logic [SAMPLE_W-1:0] sample;
    } rd_word_t;

    // Chip channel feeding a given connector output
    function automatic int unsigned src_of_panel(input int unsigned panel,
                                                 input int unsigned n_ch);
        int unsigned half;
        half = (n_ch + 1) / 2;
        return (panel % 2 == 0) ? panel / 2 : half + panel / 2;
    endfunction

    function automatic rd_word_t pack_word(input logic [SAMPLE_W-1:0] s,
                                           input logic [IDX_W-1:0]    p,
                                           input logic                f);
        rd_word_t w;
        w.pad    = '0;
        w.last   = f;
        w.panel  = p;
        w.sample = s;
        return w;
    endfunction

endpackage

// File: rtl/mux_rd_fsm.sv
module mux_rd_fsm
    import mux_rd_pkg::*;
#(
    parameter int NUM_CH      = 18,
    parameter int TIMEOUT_CYC = 64,
    localparam int CNT_W      = $clog2(NUM_CH),
    localparam int TO_W       = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             adc_busy,
    output logic             mux_clk,
    output logic             adc_conv,
    output logic             cap_en,
    output logic [CNT_W-1:0] pos,
    output logic             drain_en,
    output logic             busy,
    output logic             timeout_err
);

    seq_state_e       state_q;
    logic [CNT_W-1:0] pos_q;
    logic [TO_W-1:0]  to_q;
    logic             err_q;
    logic             last_pos;
    logic             conv_done;

    assign last_pos  = (pos_q == CNT_W'(NUM_CH - 1));
    assign conv_done = (state_q == ST_WAIT) && !adc_busy && (to_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
            to_q    <= '0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        err_q   <= 1'b0;
                        pos_q   <= '0;
                        state_q <= ST_TICK;
                    end
                end
                ST_TICK: state_q <= ST_CONV;
                ST_CONV: begin
                    to_q    <= '0;
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (conv_done) begin
                        if (last_pos) begin
                            state_q <= ST_FLUSH;
                        end else begin
                            pos_q   <= pos_q + 1'b1;
                            state_q <= ST_TICK;
                        end
                    end else if (to_q == TO_W'(TIMEOUT_CYC - 1)) begin
                        err_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        to_q <= to_q + 1'b1;
                    end
                end
                ST_FLUSH: begin
                    pos_q   <= '0;
                    state_q <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (last_pos) state_q <= ST_IDLE;
                    else          pos_q   <= pos_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mux_clk     = (state_q == ST_TICK) || (state_q == ST_FLUSH);
    assign adc_conv    = (state_q == ST_CONV);
    assign cap_en      = conv_done;
    assign pos         = pos_q;
    assign drain_en    = (state_q == ST_DRAIN);
    assign busy        = (state_q != ST_IDLE);
    assign timeout_err = err_q;

endmodule

// File: rtl/mux_rd_store.sv
module mux_rd_store
    import mux_rd_pkg::*;
#(
    parameter int NUM_CH = 18,
    localparam int CNT_W = $clog2(NUM_CH)
) (
    input  logic                clk,
    input  logic                cap_en,
    input  logic [CNT_W-1:0]    pos,
    input  logic [SAMPLE_W-1:0] adc_data,
    input  logic                shift_flag,
    output rd_word_t            word
);

    logic [SAMPLE_W-1:0] samp_q [NUM_CH];
    logic [NUM_CH-1:0]   flag_q;
    logic [CNT_W-1:0]    src;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (cap_en && pos == CNT_W'(i)) begin
                samp_q[i] <= adc_data;
                flag_q[i] <= shift_flag;
            end
        end
    end

    always_comb begin
        src  = CNT_W'(src_of_panel(32'(pos), NUM_CH));
        word = pack_word(samp_q[src], IDX_W'(pos), flag_q[src]);
    end

endmodule

// File: rtl/mux_rd_regs.sv
module mux_rd_regs #(
    parameter int          ADDR_W       = 8,
    parameter int          DATA_W       = 32,
    parameter int          VERSION_ADDR = 49,
    parameter logic [31:0] VERSION      = 32'h0001_0004
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= (rd_addr == ADDR_W'(VERSION_ADDR)) ? DATA_W'(VERSION) : '0;
        end
    end

endmodule

// File: rtl/mux_adc_readout.sv
module mux_adc_readout
    import mux_rd_pkg::*;
#(
    parameter int          NUM_CH       = 18,
    parameter int          TIMEOUT_CYC  = 64,
    parameter int          ADDR_W       = 8,
    parameter int          VERSION_ADDR = 49,
    parameter logic [31:0] VERSION      = 32'h0001_0004
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    output logic                mux_clk,
    output logic                adc_conv,
    input  logic                adc_busy,
    input  logic [SAMPLE_W-1:0] adc_data,
    input  logic                shift_flag,
    output logic                fifo_wr,
    output logic [WORD_W-1:0]   fifo_wdata,
    output logic                busy,
    output logic                timeout_err,
    input  logic                host_rd_en,
    input  logic [ADDR_W-1:0]   host_rd_addr,
    output logic [WORD_W-1:0]   host_rd_data
);

    localparam int CNT_W = $clog2(NUM_CH);

    logic             cap_en;
    logic [CNT_W-1:0] pos;
    rd_word_t         word;

    mux_rd_fsm #(.NUM_CH(NUM_CH), .TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
        .clk(clk), .rst(rst), .start(start), .adc_busy(adc_busy),
        .mux_clk(mux_clk), .adc_conv(adc_conv), .cap_en(cap_en), .pos(pos),
        .drain_en(fifo_wr), .busy(busy), .timeout_err(timeout_err)
    );

    mux_rd_store #(.NUM_CH(NUM_CH)) u_store (
        .clk(clk), .cap_en(cap_en), .pos(pos), .adc_data(adc_data),
        .shift_flag(shift_flag), .word(word)
    );

    mux_rd_regs #(
        .ADDR_W(ADDR_W), .DATA_W(WORD_W),
        .VERSION_ADDR(VERSION_ADDR), .VERSION(VERSION)
    ) u_regs (
        .clk(clk), .rst(rst), .rd_en(host_rd_en), .rd_addr(host_rd_addr),
        .rd_data(host_rd_data)
    );

    assign fifo_wdata = word;

endmodule

// File: rtl/mux_adc_readout_chk.sv
module mux_adc_readout_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              mux_clk,
    input logic              adc_conv,
    input logic              fifo_wr,
    input logic [WORD_W-1:0] fifo_wdata,
    input logic              busy,
    input logic              timeout_err
);

    AST_RST_QUIET: assert property (@(posedge clk)
        rst |=> (!mux_clk && !adc_conv && !fifo_wr && !busy && !timeout_err)); // R9

    AST_WR_APART: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> (!mux_clk && !adc_conv)); // R2

    AST_TICK_NO_CONV: assert property (@(posedge clk) disable iff (rst)
        !(mux_clk && adc_conv)); // R1

    AST_CONV_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        adc_conv |-> $past(mux_clk)); // R1

    AST_CONV_PULSE: assert property (@(posedge clk) disable iff (rst)
        adc_conv |=> !adc_conv); // R11

    AST_TICK_PULSE: assert property (@(posedge clk) disable iff (rst)
        mux_clk |=> !mux_clk); // R11

    AST_WORD_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> (fifo_wdata[WORD_W-1:22] == '0)); // R3

    AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_err) |-> !busy); // R7

endmodule

bind mux_adc_readout mux_adc_readout_chk #(.WORD_W(32)) u_chk (
    .clk(clk), .rst(rst), .mux_clk(mux_clk), .adc_conv(adc_conv),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .busy(busy),
    .timeout_err(timeout_err)
);

// File: tb/mux_adc_readout_bench.sv
module mux_adc_readout_bench;

    localparam int          NUM_CH  = 18;
    localparam int          TO_CYC  = 24;
    localparam logic [31:0] VERSION = 32'hA5C3_0107;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        mux_clk, adc_conv, fifo_wr, busy, timeout_err;
    logic        adc_busy = 1'b0;
    logic [15:0] adc_data = 16'h0;
    logic        shift_flag = 1'b0;
    logic [31:0] fifo_wdata, host_rd_data;
    logic        host_rd_en = 1'b0;
    logic [7:0]  host_rd_addr = 8'h0;

    always #5 clk = ~clk;

    mux_adc_readout #(
        .NUM_CH(NUM_CH), .TIMEOUT_CYC(TO_CYC), .VERSION(VERSION)
    ) u_mux_adc_readout (
        .clk(clk), .rst(rst), .start(start), .mux_clk(mux_clk),
        .adc_conv(adc_conv), .adc_busy(adc_busy), .adc_data(adc_data),
        .shift_flag(shift_flag), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .busy(busy), .timeout_err(timeout_err), .host_rd_en(host_rd_en),
        .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data)
    );

    int n_chk = 0, n_err = 0;
    int n_ticks, n_conv, n_wr, tick_cnt, ticks_at_wr, busy_left;
    bit stuck = 1'b0;
    logic [15:0] pending;
    logic [15:0] exp_samp [64];
    logic [31:0] got [64];

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int j);
        int src;
        src = (j % 2 == 0) ? j / 2 : (NUM_CH + 1) / 2 + j / 2;
        return {10'd0, (src == NUM_CH - 1), 5'(j), exp_samp[src]};
    endfunction

    // Chip, ADC and FIFO models, all acting away from the active edge
    always @(negedge clk) begin
        if (mux_clk) begin
            n_ticks++;
            tick_cnt++;
            shift_flag = (tick_cnt == NUM_CH);
        end
        if (adc_conv) begin
            n_conv++;
            adc_busy = 1'b1;
            if (stuck) begin
                busy_left = 0;
            end else begin
                busy_left = 1 + int'($urandom % 6);
                pending   = 16'($urandom);
                if (n_conv <= 64) exp_samp[n_conv-1] = pending;
                adc_data  = ~pending;
            end
        end else if (busy_left > 0) begin
            busy_left--;
            if (busy_left == 0) begin
                adc_busy = 1'b0;
                adc_data = pending;
            end
        end
        if (fifo_wr) begin
            if (n_wr == 0) ticks_at_wr = n_ticks;
            if (n_wr < 64) got[n_wr] = fifo_wdata;
            n_wr++;
        end
    end

    task automatic clear_counts();
        n_ticks = 0; n_conv = 0; n_wr = 0; tick_cnt = 0; ticks_at_wr = -1;
        shift_flag = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        host_rd_en = 1'b1; host_rd_addr = a;
        @(negedge clk);
        host_rd_en = 1'b0;
        chk(host_rd_data == exp, "R10 host read", host_rd_data, exp);
    endtask

    task automatic run_seq(input bit with_start, input bit with_reads);
        int cyc, flags;
        clear_counts();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc = 0;
        while (busy && cyc < 3000) begin
            if (with_start) start = (cyc == 25);
            if (with_reads) begin
                host_rd_en   = 1'($urandom % 2);
                host_rd_addr = 8'($urandom % 64);
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0; host_rd_en = 1'b0;
        chk(n_ticks == NUM_CH + 1, "R1 tick count", n_ticks, NUM_CH + 1);
        chk(n_conv == NUM_CH, "R1 conversion count", n_conv, NUM_CH);
        chk(n_wr == NUM_CH, "R2 word count", n_wr, NUM_CH);
        chk(ticks_at_wr == NUM_CH + 1, "R2 writes after final tick", ticks_at_wr, NUM_CH + 1);
        chk(shift_flag == 1'b0, "R1 flag cleared by trailing tick", shift_flag, 0);
        if (with_start) chk(n_ticks == NUM_CH + 1, "R8 start during run ignored", n_ticks, NUM_CH + 1);
        if (with_reads) chk(n_wr == NUM_CH, "R10 reads leave FIFO alone", n_wr, NUM_CH);
        flags = 0;
        for (int j = 0; j < NUM_CH && j < n_wr; j++) begin
            chk(got[j] == exp_word(j), "R3/R4/R6 word content and order", got[j], exp_word(j));
            flags += int'(got[j][21]);
        end
        chk(flags == 1, "R5 one flagged word", flags, 1);
        chk(got[NUM_CH-1][21] == 1'b1, "R5 last word flagged", got[NUM_CH-1], 32'h0020_0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int cyc;
        clear_counts();
        busy_left = 0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({mux_clk, adc_conv, fifo_wr, busy, timeout_err} == 5'b0,
            "R9 reset state", {mux_clk, adc_conv, fifo_wr, busy, timeout_err}, 0);
        chk(host_rd_data == 0, "R9 reset read data", host_rd_data, 0);

        // Idle host reads: version, neighbours, no side effects
        host_read(8'd49, VERSION);
        host_read(8'd48, 32'h0);
        host_read(8'd50, 32'h0);
        host_read(8'd49, VERSION);
        host_read(8'd0, 32'h0);
        repeat (3) @(negedge clk);
        chk(n_ticks == 0 && n_wr == 0 && !busy, "R10 idle reads start nothing", n_ticks + n_wr, 0);

        run_seq(1'b0, 1'b0);
        for (int r = 0; r < 6; r++) begin
            run_seq(1'($urandom % 2), 1'($urandom % 2));
            repeat (int'($urandom % 4)) @(negedge clk);
        end

        // Stuck ADC busy
        stuck = 1'b1;
        clear_counts();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc = 0;
        while (busy && cyc < 3000) begin @(negedge clk); cyc++; end
        chk(timeout_err == 1'b1, "R7 timeout flagged", timeout_err, 1);
        chk(cyc >= TO_CYC && cyc <= TO_CYC + 4, "R7 timeout window", cyc, TO_CYC);
        chk(n_conv == 1 && n_wr == 0, "R7 no words after timeout", n_wr, 0);
        stuck = 1'b0; adc_busy = 1'b0;
        run_seq(1'b0, 1'b0);
        chk(timeout_err == 1'b0, "R7 error cleared by start", timeout_err, 0);

        // Reset in the middle of a readout
        clear_counts();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk({mux_clk, adc_conv, fifo_wr, busy} == 4'b0, "R9 mid-run reset",
            {mux_clk, adc_conv, fifo_wr, busy}, 0);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        chk(!busy && n_wr == 0, "R9 stays idle after reset", n_wr, 0);

        run_seq(1'b1, 1'b1);
        host_read(8'd49, VERSION);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule